// File: doc/BRIEF.md
# Indexed Real-Time Clock Register Bank

This block is a calendar clock that software reaches through two byte-wide ports. A write to the index port picks one internal register; the next access to the data port reads or writes that register. The clock holds seconds, minutes, hours (24-hour form), day of month, month and a two-digit year. It advances by one second for each pulse on a once-per-second enable input.

A pulse on the enable input does not change the time at once. It opens an update window of a fixed number of clocks. A status flag is raised for the whole window, and the time fields are advanced at its end. Software that sees the flag clear knows that no update can begin before the next pulse. A mode bit selects how time bytes appear on the data port, as packed BCD or as plain binary. Internally the time is always held in binary, so switching the mode changes only how the values are presented.

Top module: `rtc_index_bank`

## Requirements
- R1: A write with `bus_addr`=0 loads the index register; an access with `bus_addr`=1 reads or writes the register selected by the index; a read at `bus_addr`=0 returns the index. `bus_rdata` carries the read result from the clock edge that accepts the read strobe.
- R2: Time fields sit at these indexes: 0x00 seconds, 0x02 minutes, 0x04 hours, 0x07 day of month, 0x08 month, 0x09 year (00..99).
- R3: After reset the time is 00:00:00, day 01, month 01, year 00, the encoding is BCD, and the update flag is clear.
- R4: Status A (index 0x0A) has the update flag in bit 7; its other bits read 0 and writes to it are ignored. The flag is set from the first edge after a pulse is sampled for LEAD_CYCLES clocks, and it clears on the edge that applies the increment.
- R5: The one-second increment is applied LEAD_CYCLES edges after the edge that samples the enable pulse, and a pulse that arrives while a window is open is ignored.
- R6: Seconds and minutes wrap from 59 to 0 and carry; hours wrap from 23 to 0 and carry into the day.
- R7: The day wraps to 1 after the last day of the month: 30 for months 4, 6, 9 and 11; 28 for month 2, or 29 when the year is divisible by 4; 31 for the rest.
- R8: The month wraps from 12 to 1 and carries into the year; the year wraps from 99 to 00.
- R9: Status B (index 0x0B) holds the encoding bit in bit 2 (0 = BCD, 1 = binary); the other bits read 0.
- R10: A data-port write to a time field takes effect on the accepting edge and is interpreted in the selected encoding; time reads use the same encoding.
- R11: A read of any index that is not a time field or a status register returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = index port, 1 = data port |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, registered |
| pps_en | input | 1 | One-per-second advance enable |

## Verification
A read result is due on `bus_rdata` right after the edge that accepts the strobe, so each bus task samples one time unit after that edge. The update flag is due from the first edge after the edge that samples the pulse. The bench puts the index on status A in advance and then reads on consecutive edges. It expects the flag on reads 1 to LEAD_CYCLES and a clear flag on the next read, because the register takes the flag value from before the edge. Time checks wait LEAD_CYCLES plus two edges after a pulse before reading, so the increment has been applied before the read.

// File: rtl/rtc_pkg.sv
// Shared types and pure functions for the indexed real-time clock.
// Assumes time values are kept in binary and converted only at the port.
package rtc_pkg;

    localparam logic [7:0] IDX_SEC  = 8'h00;
    localparam logic [7:0] IDX_MIN  = 8'h02;
    localparam logic [7:0] IDX_HR   = 8'h04;
    localparam logic [7:0] IDX_DAY  = 8'h07;
    localparam logic [7:0] IDX_MON  = 8'h08;
    localparam logic [7:0] IDX_YR   = 8'h09;
    localparam logic [7:0] IDX_STA  = 8'h0A;
    localparam logic [7:0] IDX_STB  = 8'h0B;

    typedef enum logic [3:0] {
        FLD_SEC, FLD_MIN, FLD_HR, FLD_DAY, FLD_MON, FLD_YR,
        FLD_STA, FLD_STB, FLD_NONE
    } rtc_field_e;

    typedef struct packed {
        logic [6:0] yr;
        logic [6:0] mon;
        logic [6:0] day;
        logic [6:0] hr;
        logic [6:0] min;
        logic [6:0] sec;
    } rtc_time_t;

    // Map an index byte to the register it selects.
    function automatic rtc_field_e decode_idx(input logic [7:0] idx);
        case (idx)
            IDX_SEC: return FLD_SEC;
            IDX_MIN: return FLD_MIN;
            IDX_HR:  return FLD_HR;
            IDX_DAY: return FLD_DAY;
            IDX_MON: return FLD_MON;
            IDX_YR:  return FLD_YR;
            IDX_STA: return FLD_STA;
            IDX_STB: return FLD_STB;
            default: return FLD_NONE;
        endcase
    endfunction

    // Packed BCD byte to binary value.
    function automatic logic [6:0] bcd_to_bin(input logic [7:0] b);
        return 7'({3'b0, b[7:4]} * 7'd10 + {3'b0, b[3:0]});
    endfunction

    // Binary value (0..99) to packed BCD byte.
    function automatic logic [7:0] bin_to_bcd(input logic [6:0] v);
        return {4'(v / 7'd10), 4'(v % 7'd10)};
    endfunction

    // Last day of a month, with the leap rule for years divisible by 4.
    function automatic logic [6:0] month_days(input logic [6:0] mon, input logic [6:0] yr);
        case (mon)
            7'd2:                      return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11:   return 7'd30;
            default:                   return 7'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_tick_sched.sv
// Update-window scheduler: a sampled pps pulse opens a window of
// LEAD_CYCLES clocks with the busy flag high; the last cycle issues the
// step strobe. Assumes LEAD_CYCLES >= 1; pulses inside a window are dropped.
module rtc_tick_sched #(
    parameter int LEAD_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pps_en,
    output logic uip,
    output logic step
);
    localparam int CW = $clog2(LEAD_CYCLES + 1);

    logic          uip_q;
    logic [CW-1:0] cnt_q;

    // Step fires in the final cycle of an open window.
    always_comb step = uip_q && (cnt_q == '0);

    // Window open/count/close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uip_q <= 1'b0;
            cnt_q <= '0;
        end else if (!uip_q) begin
            if (pps_en) begin
                uip_q <= 1'b1;
                cnt_q <= CW'(LEAD_CYCLES - 1);
            end
        end else if (step) begin
            uip_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign uip = uip_q;

    AST_UIP_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (pps_en && !uip_q) |=> uip_q);                         // R4
    AST_STEP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !uip_q);                                      // R4
    AST_PPS_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (uip_q && !step) |=> uip_q);                           // R5

endmodule

// File: rtl/rtc_time_core.sv
// Calendar state in binary with the one-second carry chain. A software
// write to a field overrides that field after the step in the same cycle.
module rtc_time_core
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic       wr_en,
    input  rtc_field_e wr_field,
    input  logic [6:0] wr_value,
    output rtc_time_t  now
);
    rtc_time_t t_q, t_inc, t_nxt;
    logic c_min, c_hr, c_day, c_mon, c_yr;

    // Carry chain for one second.
    always_comb begin
        t_inc = t_q;
        c_min = (t_q.sec >= 7'd59);
        c_hr  = c_min && (t_q.min >= 7'd59);
        c_day = c_hr  && (t_q.hr  >= 7'd23);
        c_mon = c_day && (t_q.day >= month_days(t_q.mon, t_q.yr));
        c_yr  = c_mon && (t_q.mon >= 7'd12);
        t_inc.sec = c_min ? 7'd0 : t_q.sec + 7'd1;
        if (c_min) t_inc.min = c_hr  ? 7'd0 : t_q.min + 7'd1;
        if (c_hr)  t_inc.hr  = c_day ? 7'd0 : t_q.hr  + 7'd1;
        if (c_day) t_inc.day = c_mon ? 7'd1 : t_q.day + 7'd1;
        if (c_mon) t_inc.mon = c_yr  ? 7'd1 : t_q.mon + 7'd1;
        if (c_yr)  t_inc.yr  = (t_q.yr >= 7'd99) ? 7'd0 : t_q.yr + 7'd1;
    end

    // Merge step and software write.
    always_comb begin
        t_nxt = step ? t_inc : t_q;
        if (wr_en) begin
            case (wr_field)
                FLD_SEC: t_nxt.sec = wr_value;
                FLD_MIN: t_nxt.min = wr_value;
                FLD_HR:  t_nxt.hr  = wr_value;
                FLD_DAY: t_nxt.day = wr_value;
                FLD_MON: t_nxt.mon = wr_value;
                FLD_YR:  t_nxt.yr  = wr_value;
                default: ;
            endcase
        end
    end

    // Time register with reset to 00:00:00 01/01/00.
    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '{yr: 7'd0, mon: 7'd1, day: 7'd1, hr: 7'd0, min: 7'd0, sec: 7'd0};
        else        t_q <= t_nxt;
    end

    assign now = t_q;

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_en) |=> (t_q.sec < 7'd60));               // R6
    AST_HR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_en) |=> (t_q.hr < 7'd24));                // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !wr_en) |=> $stable(t_q));                   // R5

endmodule

// File: rtl/rtc_port_if.sv
// Index/data port front end: holds the index and the encoding bit,
// converts between port encoding and binary, registers read data.
module rtc_port_if
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_cs,
    input  logic       bus_we,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    input  rtc_time_t  now,
    input  logic       uip,
    output logic [7:0] bus_rdata,
    output logic       wr_en,
    output rtc_field_e wr_field,
    output logic [6:0] wr_value
);
    logic [7:0] idx_q;
    logic       bin_mode_q;
    logic [7:0] rd_q;
    logic [7:0] rd_byte;
    logic [6:0] field_bin;
    rtc_field_e sel;

    always_comb sel = decode_idx(idx_q);

    // Time write request toward the core.
    always_comb begin
        wr_en    = bus_cs && bus_we && bus_addr;
        wr_field = sel;
        wr_value = bin_mode_q ? bus_wdata[6:0] : bcd_to_bin(bus_wdata);
    end

    // Select the field and present it in the chosen encoding.
    always_comb begin
        field_bin = 7'd0;
        case (sel)
            FLD_SEC: field_bin = now.sec;
            FLD_MIN: field_bin = now.min;
            FLD_HR:  field_bin = now.hr;
            FLD_DAY: field_bin = now.day;
            FLD_MON: field_bin = now.mon;
            FLD_YR:  field_bin = now.yr;
            default: ;
        endcase
        case (sel)
            FLD_STA:  rd_byte = {uip, 7'b0};
            FLD_STB:  rd_byte = {5'b0, bin_mode_q, 2'b0};
            FLD_NONE: rd_byte = 8'h00;
            default:  rd_byte = bin_mode_q ? {1'b0, field_bin} : bin_to_bcd(field_bin);
        endcase
    end

    // Index, encoding bit and read register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q      <= 8'h00;
            bin_mode_q <= 1'b0;
            rd_q       <= 8'h00;
        end else if (bus_cs) begin
            if (bus_we && !bus_addr) idx_q <= bus_wdata;
            if (bus_we && bus_addr && sel == FLD_STB) bin_mode_q <= bus_wdata[2];
            if (!bus_we) rd_q <= bus_addr ? rd_byte : idx_q;
        end
    end

    assign bus_rdata = rd_q;

    AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && !bus_we && bus_addr && sel == FLD_NONE) |=> (bus_rdata == 8'h00)); // R11
    AST_STA_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && !bus_we && bus_addr && sel == FLD_STA) |=> (bus_rdata[6:0] == 7'd0)); // R4
    AST_IDX_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && !bus_we && !bus_addr) |=> (bus_rdata == $past(idx_q)));  // R1

endmodule

// File: rtl/rtc_index_bank.sv
// Top of the indexed real-time clock: port front end, update scheduler
// and calendar core. Assumes one access per strobe cycle.
module rtc_index_bank #(
    parameter int LEAD_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_cs,
    input  logic       bus_we,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       pps_en
);
    import rtc_pkg::*;

    logic       uip, step, wr_en;
    rtc_field_e wr_field;
    logic [6:0] wr_value;
    rtc_time_t  now;

    rtc_tick_sched #(.LEAD_CYCLES(LEAD_CYCLES)) u_sched (
        .clk(clk), .rst_n(rst_n), .pps_en(pps_en), .uip(uip), .step(step)
    );

    rtc_time_core u_core (
        .clk(clk), .rst_n(rst_n), .step(step), .wr_en(wr_en),
        .wr_field(wr_field), .wr_value(wr_value), .now(now)
    );

    rtc_port_if u_port (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .now(now), .uip(uip),
        .bus_rdata(bus_rdata), .wr_en(wr_en), .wr_field(wr_field),
        .wr_value(wr_value)
    );

endmodule

// File: tb/rtc_index_bank_bench.sv
// Directed bench: one task per scenario, each checking its own reads.
module rtc_index_bank_bench;
    localparam int LEAD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cs = 1'b0;
    logic       bus_we = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       pps_en = 1'b0;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    rtc_index_bank #(.LEAD_CYCLES(LEAD)) u_rtc_index_bank (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pps_en(pps_en)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_cs = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        d = bus_rdata;
        bus_cs = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
        bus_write(1'b0, idx);
        bus_write(1'b1, d);
    endtask

    task automatic reg_chk(input string req, input logic [7:0] idx, input logic [7:0] exp);
        logic [7:0] v;
        bus_write(1'b0, idx);
        bus_read(1'b1, v);
        check(req, v, exp);
    endtask

    task automatic tick();
        @(negedge clk); pps_en = 1'b1;
        @(posedge clk); #1 pps_en = 1'b0;
        repeat (LEAD + 2) @(posedge clk);
    endtask

    task automatic set_all(input logic [7:0] y, mo, d, h, mi, s);
        reg_wr(8'h09, y); reg_wr(8'h08, mo); reg_wr(8'h07, d);
        reg_wr(8'h04, h); reg_wr(8'h02, mi); reg_wr(8'h00, s);
    endtask

    task automatic t_reset();
        reg_chk("R3 sec", 8'h00, 8'h00);
        reg_chk("R3 min", 8'h02, 8'h00);
        reg_chk("R3 hour", 8'h04, 8'h00);
        reg_chk("R3 day", 8'h07, 8'h01);
        reg_chk("R3 month", 8'h08, 8'h01);
        reg_chk("R3 year", 8'h09, 8'h00);
        reg_chk("R3 statusB", 8'h0B, 8'h00);
        reg_chk("R3 statusA", 8'h0A, 8'h00);
    endtask

    task automatic t_index_port();
        logic [7:0] v;
        bus_write(1'b0, 8'h09);
        bus_read(1'b0, v);
        check("R1 index readback", v, 8'h09);
        reg_wr(8'h02, 8'h37);
        reg_chk("R1 R2 minutes at 0x02", 8'h02, 8'h37);
        reg_chk("R2 seconds unchanged", 8'h00, 8'h00);
    endtask

    task automatic t_uip();
        logic [7:0] v;
        reg_wr(8'h00, 8'h05);
        bus_write(1'b0, 8'h0A);
        @(negedge clk); pps_en = 1'b1;
        @(posedge clk); #1 pps_en = 1'b0;
        for (int k = 1; k <= LEAD + 1; k++) begin
            bus_read(1'b1, v);
            check("R4 uip flag", v, (k <= LEAD) ? 8'h80 : 8'h00);
        end
        reg_chk("R5 one increment", 8'h00, 8'h06);
        reg_wr(8'h0A, 8'hFF);
        reg_chk("R4 statusA write ignored", 8'h0A, 8'h00);
    endtask

    task automatic t_pps_in_window();
        reg_wr(8'h00, 8'h20);
        @(negedge clk); pps_en = 1'b1;
        @(posedge clk); #1 pps_en = 1'b0;
        @(posedge clk);
        @(negedge clk); pps_en = 1'b1;
        @(posedge clk); #1 pps_en = 1'b0;
        repeat (3 * LEAD) @(posedge clk);
        reg_chk("R5 pulse in window ignored", 8'h00, 8'h21);
    endtask

    task automatic t_bcd_carry();
        reg_wr(8'h00, 8'h09);
        tick();
        reg_chk("R10 BCD digit carry", 8'h00, 8'h10);
        set_all(8'h07, 8'h05, 8'h14, 8'h10, 8'h59, 8'h59);
        tick();
        reg_chk("R6 min carry sec", 8'h00, 8'h00);
        reg_chk("R6 min carry min", 8'h02, 8'h00);
        reg_chk("R6 min carry hour", 8'h04, 8'h11);
    endtask

    task automatic t_year_wrap();
        set_all(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
        tick();
        reg_chk("R8 year wrap", 8'h09, 8'h00);
        reg_chk("R8 month wrap", 8'h08, 8'h01);
        reg_chk("R7 day wrap", 8'h07, 8'h01);
        reg_chk("R6 hour wrap", 8'h04, 8'h00);
    endtask

    task automatic t_months();
        set_all(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
        tick();
        reg_chk("R7 leap Feb 29", 8'h07, 8'h29);
        reg_wr(8'h04, 8'h23); reg_wr(8'h02, 8'h59); reg_wr(8'h00, 8'h59);
        tick();
        reg_chk("R7 leap to Mar day", 8'h07, 8'h01);
        reg_chk("R7 leap to Mar month", 8'h08, 8'h03);
        set_all(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
        tick();
        reg_chk("R7 common Feb end", 8'h08, 8'h03);
        set_all(8'h23, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
        tick();
        reg_chk("R7 April 30 end", 8'h08, 8'h05);
        set_all(8'h23, 8'h01, 8'h30, 8'h23, 8'h59, 8'h59);
        tick();
        reg_chk("R7 Jan 31 exists", 8'h07, 8'h31);
    endtask

    task automatic t_binary();
        reg_wr(8'h00, 8'h45);
        reg_wr(8'h0B, 8'hFF);
        reg_chk("R9 statusB only bit2", 8'h0B, 8'h04);
        reg_chk("R9 binary read of 45", 8'h00, 8'h2D);
        reg_wr(8'h00, 8'h3B); reg_wr(8'h02, 8'h3B); reg_wr(8'h04, 8'h05);
        tick();
        reg_chk("R10 binary hour carry", 8'h04, 8'h06);
        reg_chk("R10 binary minutes", 8'h02, 8'h00);
        reg_wr(8'h0B, 8'h00);
        reg_wr(8'h00, 8'h17);
        reg_chk("R9 back to BCD", 8'h00, 8'h17);
    endtask

    task automatic t_undefined();
        reg_chk("R11 idx 0x01", 8'h01, 8'h00);
        reg_chk("R11 idx 0x05", 8'h05, 8'h00);
        reg_chk("R11 idx 0x0C", 8'h0C, 8'h00);
        reg_chk("R11 idx 0x7F", 8'h7F, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_index_port();
        t_uip();
        t_pps_in_window();
        t_bcd_carry();
        t_year_wrap();
        t_months();
        t_binary();
        t_undefined();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule